// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a physical page number by reading a two-level page table in hardware. A caller presents a 20-bit virtual page number and the page number of the root table. The block then fetches one 32-bit table entry per level from a physical word memory and reports either a resolved 22-bit physical page number with its leaf entry, or a page fault. The physical page number and a 12-bit offset together form a 34-bit physical address, so the physical space is wider than the 32-bit virtual one.

The virtual page number splits into an upper 10-bit index, which selects the first-level entry, and a lower 10-bit index, which selects the second-level entry. An entry whose read, write and execute bits are all clear points to the next table. Any other valid entry is a leaf. A first-level leaf maps a large page. Only one walk runs at a time. Table reads go out over a valid/ready request channel and come back after a fixed number of cycles.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and after it is released with no request, `busy`, `walk_done`, `walk_fault` and `mem_req_valid` are all low.
- R2: The first read of a walk goes to byte address root_ppn*4096 + req_vpn[19:10]*4, given as a 34-bit value.
- R3: After a pointer entry at the first level, the second read goes to byte address entry[31:10]*4096 + req_vpn[9:0]*4.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change in the next cycle.
- R5: An entry with V (bit 0) clear, at either level, ends the walk with a fault, and no further read is issued.
- R6: An entry with V=1, W (bit 2) set and R (bit 1) clear is reserved and ends the walk with a fault.
- R7: A first-level leaf (V=1 and any of R, W, X (bit 3) set) with bits 19:10 equal to zero completes with result page {entry[31:20], req_vpn[9:0]} after one read. If those bits are nonzero, the walk faults.
- R8: A second-level entry that is valid with R, W and X all clear faults.
- R9: A valid second-level leaf completes with `res_ppn` equal to entry[31:10] and `res_pte` equal to the whole entry.
- R10: `busy` is high from the cycle after a request is accepted until the one-cycle `walk_done` or `walk_fault` pulse. The two pulses never occur together. Requests raised while busy are ignored and start no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_vpn | input | 20 | Virtual page number to translate |
| req_root_ppn | input | 22 | Page number of the root table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 34 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid (fixed latency after accept) |
| mem_rsp_data | input | 32 | Entry word read from memory |
| walk_done | output | 1 | One-cycle pulse: translation found |
| walk_fault | output | 1 | One-cycle pulse: page fault |
| res_ppn | output | 22 | Resolved physical page number (valid with done) |
| res_pte | output | 32 | Last entry read, held after the pulse |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only once for each accepted request, and only while the walker is waiting for it. They also assume that `req_vpn` and `req_root_ppn` are steady during the cycle `req_valid` is seen. The bench memory model answers each accepted read exactly once after a fixed two-cycle delay, and changes `ready` only on a fixed stall pattern. It holds a fresh table image for every walk. The sweeps cover all 16 low flag combinations at each level, with zero and nonzero low page bits, so every class of entry is hit.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // walk sequencer states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT
   } walk_st_e;

   // entry classification
   typedef enum logic [1:0] {
      PTE_INVALID,
      PTE_RESERVED,
      PTE_POINTER,
      PTE_LEAF
   } pte_kind_e;

   // flag bit positions inside an entry
   localparam int FLAG_V = 0;
   localparam int FLAG_R = 1;
   localparam int FLAG_W = 2;
   localparam int FLAG_X = 3;
   // number of low entry bits below the page number field
   localparam int PTE_LOW_BITS = 10;

endpackage

// File: rtl/ptw_pte_class.sv
module ptw_pte_class
   import ptw_pkg::*;
#(
   parameter int PTE_W = 32
) (
   input  logic [PTE_W-1:0] pte,
   output pte_kind_e        kind
);

   logic v_b, r_b, w_b, x_b;

   assign v_b = pte[FLAG_V];
   assign r_b = pte[FLAG_R];
   assign w_b = pte[FLAG_W];
   assign x_b = pte[FLAG_X];

   always_comb begin
      if (!v_b)
         kind = PTE_INVALID;
      else if (w_b && !r_b)
         kind = PTE_RESERVED;
      else if (!r_b && !w_b && !x_b)
         kind = PTE_POINTER;
      else
         kind = PTE_LEAF;
   end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PPN_W = 22,
   parameter int IDX_W = 10,
   parameter int OFF_W = 12,
   parameter int PA_W  = PPN_W + OFF_W
) (
   input  logic [PPN_W-1:0] tbl_ppn,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  pte_addr
);

   localparam int ENTRY_SHIFT = 2;   // 4-byte entries

   generate
      if (PA_W != PPN_W + OFF_W) begin : g_bad_pa
         $error("ptw_addr_gen: PA_W must equal PPN_W + OFF_W");
      end
      if (OFF_W < IDX_W + ENTRY_SHIFT) begin : g_bad_off
         $error("ptw_addr_gen: table of 2**IDX_W entries must fit in a page");
      end
   endgenerate

   logic [PA_W-1:0] base_w;
   logic [PA_W-1:0] disp_w;

   assign base_w   = {tbl_ppn, {OFF_W{1'b0}}};
   assign disp_w   = PA_W'({idx, {ENTRY_SHIFT{1'b0}}});
   assign pte_addr = base_w + disp_w;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VPN_IDX_W    = 10,
   parameter int PG_OFF_W     = 12,
   parameter int PPN_HI_W     = 12,
   parameter int PPN_LO_W     = 10,
   parameter int PTE_W        = 32,
   parameter bit SUPERPAGE_EN = 1'b1,
   localparam int VPN_W       = 2 * VPN_IDX_W,
   localparam int PPN_W       = PPN_HI_W + PPN_LO_W,
   localparam int PA_W        = PPN_W + PG_OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [PPN_W-1:0] req_root_ppn,
   output logic             busy,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             walk_done,
   output logic             walk_fault,
   output logic [PPN_W-1:0] res_ppn,
   output logic [PTE_W-1:0] res_pte
);

   generate
      if (PTE_W != PPN_W + PTE_LOW_BITS) begin : g_bad_pte
         $error("ptw_walker: entry width must hold the page number and low bits");
      end
      if (PPN_LO_W != VPN_IDX_W) begin : g_bad_lo
         $error("ptw_walker: low page field must match the level index width");
      end
      if (PG_OFF_W != VPN_IDX_W + 2) begin : g_bad_off
         $error("ptw_walker: one table must fill exactly one page");
      end
   endgenerate

   walk_st_e         st_q;
   logic [VPN_W-1:0] vpn_q;
   logic [PPN_W-1:0] tbl_q;
   logic             done_q, fault_q;
   logic [PPN_W-1:0] ppn_q;
   logic [PTE_W-1:0] pte_q;

   logic [VPN_IDX_W-1:0] vpn_hi, vpn_lo, idx_sel;
   logic                 lvl2;
   pte_kind_e            kind;
   logic [PPN_W-1:0]     ent_ppn;
   logic [PPN_HI_W-1:0]  ent_hi;
   logic [PPN_LO_W-1:0]  ent_lo;
   logic                 super_ok;

   assign vpn_hi  = vpn_q[VPN_W-1 -: VPN_IDX_W];
   assign vpn_lo  = vpn_q[VPN_IDX_W-1:0];
   assign lvl2    = (st_q == ST_L2_REQ) || (st_q == ST_L2_WAIT);
   assign idx_sel = lvl2 ? vpn_lo : vpn_hi;

   assign ent_ppn = mem_rsp_data[PTE_W-1 -: PPN_W];
   assign ent_hi  = mem_rsp_data[PTE_W-1 -: PPN_HI_W];
   assign ent_lo  = mem_rsp_data[PTE_LOW_BITS +: PPN_LO_W];

   ptw_pte_class #(.PTE_W(PTE_W)) u_class (
      .pte  (mem_rsp_data),
      .kind (kind)
   );

   ptw_addr_gen #(
      .PPN_W (PPN_W),
      .IDX_W (VPN_IDX_W),
      .OFF_W (PG_OFF_W),
      .PA_W  (PA_W)
   ) u_addr (
      .tbl_ppn  (tbl_q),
      .idx      (idx_sel),
      .pte_addr (mem_req_addr)
   );

   // large-page leaves at level one: allowed only when aligned
   generate
      if (SUPERPAGE_EN) begin : g_super
         assign super_ok = (ent_lo == '0);
      end else begin : g_no_super
         assign super_ok = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         vpn_q   <= '0;
         tbl_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         ppn_q   <= '0;
         pte_q   <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vpn_q <= req_vpn;
                  tbl_q <= req_root_ppn;
                  st_q  <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: begin
               if (mem_req_ready) st_q <= ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  if (kind == PTE_POINTER) begin
                     tbl_q <= ent_ppn;
                     st_q  <= ST_L2_REQ;
                  end else begin
                     pte_q <= mem_rsp_data;
                     st_q  <= ST_IDLE;
                     if (kind == PTE_LEAF && super_ok) begin
                        done_q <= 1'b1;
                        ppn_q  <= {ent_hi, vpn_lo};
                     end else begin
                        fault_q <= 1'b1;
                     end
                  end
               end
            end
            ST_L2_REQ: begin
               if (mem_req_ready) st_q <= ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  pte_q <= mem_rsp_data;
                  st_q  <= ST_IDLE;
                  if (kind == PTE_LEAF) begin
                     done_q <= 1'b1;
                     ppn_q  <= ent_ppn;
                  end else begin
                     fault_q <= 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (st_q != ST_IDLE);
   assign mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign walk_done     = done_q;
   assign walk_fault    = fault_q;
   assign res_ppn       = ppn_q;
   assign res_pte       = pte_q;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R10
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(walk_done && walk_fault));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_done || walk_fault) |=> !(walk_done || walk_fault));

   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (walk_done || walk_fault));

   // R5
   invalid_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req_valid && mem_rsp_valid && !mem_rsp_data[FLAG_V])
         |=> (walk_fault && !mem_req_valid));

   // R8
   l2_ptr_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_L2_WAIT && mem_rsp_valid && kind == PTE_POINTER) |=> walk_fault);

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [19:0] req_vpn = '0;
   logic [21:0] req_root_ppn = '0;
   logic        busy;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [33:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        walk_done, walk_fault;
   logic [21:0] res_ppn;
   logic [31:0] res_pte;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   ptw_walker dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_vpn      (req_vpn),
      .req_root_ppn (req_root_ppn),
      .busy         (busy),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .walk_done    (walk_done),
      .walk_fault   (walk_fault),
      .res_ppn      (res_ppn),
      .res_pte      (res_pte)
   );

   // ---------------- memory model ----------------
   logic [31:0] pmem [logic [33:0]];
   logic [LAT-1:0] sh_v;
   logic [31:0]    sh_d [LAT];
   logic [33:0]    addr_log [64];
   int             n_acc = 0;
   int             rdy_cnt = 0;

   function automatic logic [31:0] mem_rd(input logic [33:0] a);
      if (pmem.exists(a)) return pmem[a];
      return 32'h0;
   endfunction

   assign mem_rsp_valid = sh_v[0];
   assign mem_rsp_data  = sh_d[0];

   always @(posedge clk) begin
      rdy_cnt       <= rdy_cnt + 1;
      mem_req_ready <= ((rdy_cnt % 3) != 1);
      if (!rst_n) begin
         sh_v <= '0;
      end else begin
         for (int i = 0; i < LAT - 1; i++) begin
            sh_v[i] <= sh_v[i+1];
            sh_d[i] <= sh_d[i+1];
         end
         sh_v[LAT-1] <= mem_req_valid && mem_req_ready;
         sh_d[LAT-1] <= mem_rd(mem_req_addr);
         if (mem_req_valid && mem_req_ready) begin
            addr_log[n_acc % 64] <= mem_req_addr;
            n_acc <= n_acc + 1;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic do_walk(input logic [19:0] vpn, input logic [21:0] root,
                          input logic [31:0] pte1, input logic [31:0] pte2,
                          input bit poke);
      logic [33:0] a1, a2;
      logic        e_fault;
      logic [21:0] e_ppn;
      logic [31:0] e_pte;
      int          e_n, base;
      string       tg;
      bit          got, prev_stall;
      logic [33:0] prev_addr;

      pmem.delete();
      a1 = {root, 12'h000} + 34'({vpn[19:10], 2'b00});
      a2 = {pte1[31:10], 12'h000} + 34'({vpn[9:0], 2'b00});
      pmem[a1] = pte1;
      if (a2 != a1) pmem[a2] = pte2;

      // expected outcome from the requirements
      e_ppn = '0; e_pte = '0;
      if (!pte1[0]) begin
         e_fault = 1; e_n = 1; tg = "R5";
      end else if (pte1[2] && !pte1[1]) begin
         e_fault = 1; e_n = 1; tg = "R6";
      end else if (pte1[3:1] == 3'b000) begin
         e_n = 2;
         if (!pte2[0]) begin
            e_fault = 1; tg = "R5";
         end else if (pte2[2] && !pte2[1]) begin
            e_fault = 1; tg = "R6";
         end else if (pte2[3:1] == 3'b000) begin
            e_fault = 1; tg = "R8";
         end else begin
            e_fault = 0; tg = "R9"; e_ppn = pte2[31:10]; e_pte = pte2;
         end
      end else begin
         e_n = 1; tg = "R7";
         if (pte1[19:10] != 10'h0) e_fault = 1;
         else begin
            e_fault = 0; e_ppn = {pte1[31:20], vpn[9:0]}; e_pte = pte1;
         end
      end

      base = n_acc;
      @(negedge clk);
      req_valid = 1'b1; req_vpn = vpn; req_root_ppn = root;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10", "busy after accept", 64'(busy), 64'd1);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      got = 0;
      for (int c = 0; c < 60 && !got; c++) begin
         @(negedge clk);
         if (prev_stall)
            chk("R4", "request held", {29'h0, mem_req_valid, mem_req_addr},
                {29'h0, 1'b1, prev_addr});
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         if (walk_done || walk_fault) got = 1;
         if (poke && !got) begin
            req_valid    = (c < 2);
            req_vpn      = ~vpn;
            req_root_ppn = ~root;
         end
      end
      req_valid = 1'b0;
      chk(tg, "walk ended", 64'(got), 64'd1);
      if (got) begin
         chk(tg, "fault flag", 64'(walk_fault), 64'(e_fault));
         chk("R10", "pulses exclusive", 64'(walk_done & walk_fault), 64'd0);
         chk("R10", "busy low at pulse", 64'(busy), 64'd0);
         if (!e_fault) begin
            chk(tg, "res_ppn", 64'(res_ppn), 64'(e_ppn));
            chk(tg, "res_pte", 64'(res_pte), 64'(e_pte));
         end
         chk(tg, "read count", 64'(n_acc - base), 64'(e_n));
         chk("R2", "level-1 address", 64'(addr_log[base % 64]), 64'(a1));
         if (e_n == 2)
            chk("R3", "level-2 address", 64'(addr_log[(base + 1) % 64]), 64'(a2));
         @(negedge clk);
         chk("R10", "pulse is one cycle", 64'(walk_done | walk_fault), 64'd0);
         if (poke) begin
            repeat (4) @(negedge clk);
            chk("R10", "request while busy ignored", 64'(n_acc - base), 64'(e_n));
            chk("R10", "idle after ignored request", 64'(busy), 64'd0);
         end
      end
   endtask

   // ---------------- stimulus ----------------
   logic [19:0] vpn_tab [3];
   logic [21:0] root_tab [3];

   initial begin
      vpn_tab[0] = 20'h00000; vpn_tab[1] = 20'hFFFFF; vpn_tab[2] = 20'h5A3C7;
      root_tab[0] = 22'h00123; root_tab[1] = 22'h3FFFFF; root_tab[2] = 22'h2A5A5;

      repeat (3) @(negedge clk);
      chk("R1", "outputs in reset",
          64'({busy, walk_done, walk_fault, mem_req_valid}), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "outputs idle after reset",
          64'({busy, walk_done, walk_fault, mem_req_valid}), 64'd0);

      // level-one entry sweep: all low flag codes, aligned and unaligned page bits
      for (int f = 0; f < 16; f++) begin
         for (int s = 0; s < 2; s++) begin
            logic [31:0] p1;
            p1 = {12'hABC ^ 12'(f), (s != 0) ? 10'h155 : 10'h000, 2'b00, 4'hC, 4'(f)};
            do_walk(vpn_tab[(f + s) % 3], root_tab[f % 3], p1,
                    {22'h1F00F, 8'hC7}, 1'b0);
         end
      end

      // level-two entry sweep with a pointer at level one
      for (int f = 0; f < 16; f++) begin
         do_walk(vpn_tab[f % 3], root_tab[(f + 1) % 3],
                 {22'h0BEEF ^ 22'(f), 8'h01},
                 {22'h30000 + 22'(f * 7), 4'h4, 4'(f)}, 1'b0);
      end

      // requests raised during a walk
      do_walk(20'h12345, 22'h00777, {22'h01234, 8'h01}, {22'h2BCDE, 8'hCF}, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule